// File: doc/BRIEF.md
# Dual-Threshold Prescaled Watchdog Timer

This block is a software watchdog. A free-running prescaler divides the system clock by 2^PRE_W. Each time the prescaler wraps, a timeout counter CNT_W bits wide advances by one step. Two reference registers are compared with that counter. One sets an early threshold that raises a sticky interrupt flag. The other sets a later threshold that issues a reset request. Each reference register keeps its enable bit in bit 0 and the threshold value in the bits above it.

Software keeps the system alive by writing the service register before the reset threshold is reached. Any write to the service register or to either reference register restarts the prescaler and the counter from zero, so a new threshold always starts from a clean count. With the default widths (15 and 15), one counter step is 32768 clocks. The longest timeout is then 2^30 clocks.

Top module: `dual_wdt`

## Requirements
- R1: After reset, both reference registers read all ones with bit 0 clear (0xFFFE at default widths). The counter reads 0, and `irq` and `rst_req` are low.
- R2: While bit 0 of the reset reference register (address 0) is 0, the prescaler and the counter stay at zero and no reset request is issued.
- R3: With reset value R enabled, `rst_req` goes high for exactly one cycle, (R+1)·2^PRE_W clock edges after the write that last restarted the count. On that same edge the counter returns to zero.
- R4: When the interrupt reference register (address 1) has bit 0 set and value I < R, the status flag, and with it `irq`, goes high (I+1)·2^PRE_W edges after the restart.
- R5: No flag is set when interrupt-reference bit 0 is 0, or when I ≥ R.
- R6: The status flag stays set until a write to address 3 with data bit 0 = 1. A write with bit 0 = 0 leaves it set.
- R7: A write of any data to address 2 restarts the prescaler and the counter. Servicing more often than the timeout prevents `rst_req`.
- R8: A write to either reference register also restarts the prescaler and the counter.
- R9: Reads are combinational. Address 0 returns the reset reference and address 1 the interrupt reference. Address 2 returns the live counter, zero-extended. Address 3 returns the flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 2 | Register select: 0 reset ref, 1 interrupt ref, 2 service, 3 status |
| wdata | input | CNT_W+1 | Write data |
| rdata | output | CNT_W+1 | Read data for `addr` |
| irq | output | 1 | Interrupt, high while the status flag is set |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench sweeps every reset threshold and every interrupt threshold of a 3-bit prescaler, 4-bit counter configuration. It measures the edge count to each event against (value+1)·8. A design that compared one step early or late, or that did not restart on a register write, would be off by whole prescaler periods. The bench also covers:
- Equal and inverted thresholds, and a disabled interrupt. A design that ignored the ordering rule or the enable bit would raise a spurious interrupt.
- A write of zero to the status register. A non-sticky flag would drop here.
- Servicing faster than the timeout. A missed service restart would let a reset through.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        SEL_RST_REF = 2'd0,
        SEL_IRQ_REF = 2'd1,
        SEL_SERVICE = 2'd2,
        SEL_STATUS  = 2'd3
    } wdt_sel_e;

    localparam int EN_BIT   = 0;
    localparam int FLAG_BIT = 0;

    typedef struct packed {
        logic rst_hit;
        logic irq_hit;
    } wdt_evt_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W:0]   wdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic             flag,
    output logic [CNT_W:0]   rdata,
    output logic [CNT_W-1:0] rst_ref,
    output logic             rst_en,
    output logic [CNT_W-1:0] irq_ref,
    output logic             irq_en,
    output logic             restart,
    output logic             clr_flag
);
    localparam int DW = CNT_W + 1;
    localparam logic [DW-1:0] REF_INIT = {{CNT_W{1'b1}}, 1'b0};

    logic [DW-1:0] rref_q, iref_q;
    wdt_sel_e      sel;

    assign sel = wdt_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            rref_q <= REF_INIT;
            iref_q <= REF_INIT;
        end else if (wr_en) begin
            case (sel)
                SEL_RST_REF: rref_q <= wdata;
                SEL_IRQ_REF: iref_q <= wdata;
                default: ;
            endcase
        end
    end

    assign rst_ref  = rref_q[DW-1:1];
    assign rst_en   = rref_q[EN_BIT];
    assign irq_ref  = iref_q[DW-1:1];
    assign irq_en   = iref_q[EN_BIT];
    assign restart  = wr_en && (sel != SEL_STATUS);
    assign clr_flag = wr_en && (sel == SEL_STATUS) && wdata[FLAG_BIT];

    always_comb begin
        case (sel)
            SEL_RST_REF: rdata = rref_q;
            SEL_IRQ_REF: rdata = iref_q;
            SEL_SERVICE: rdata = {1'b0, cnt};
            default:     rdata = {{CNT_W{1'b0}}, flag};
        endcase
    end

    // R9: reference contents change only through a write
    assert_ref_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(rref_q) && $stable(iref_q)));
endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
    parameter int PRE_W = 15,
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic             wrap_now,
    output logic [CNT_W-1:0] cnt,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;

    assign tick = run && !restart && (&pre_q);
    assign cnt  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
            if (tick) begin
                cnt_q <= wrap_now ? '0 : cnt_q + 1'b1;
            end
        end
    end

    // R2: a disabled watchdog holds its count at zero
    assert_hold_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0 && pre_q == '0));

    // R3: the counter never rolls past its top without a reset wrap
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && (&cnt_q)) |-> wrap_now);
endmodule

// File: rtl/wdt_compare.sv
module wdt_compare
    import wdt_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] rst_ref,
    input  logic [CNT_W-1:0] irq_ref,
    input  logic             irq_en,
    input  logic             clr_flag,
    output logic             rst_hit,
    output logic             flag,
    output logic             rst_req
);
    wdt_evt_t evt;
    logic     flag_q, req_q;

    always_comb begin
        evt.rst_hit = tick && (cnt == rst_ref);
        evt.irq_hit = tick && irq_en && (cnt == irq_ref) && (irq_ref < rst_ref);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            req_q <= evt.rst_hit;
            if (evt.irq_hit)   flag_q <= 1'b1;
            else if (clr_flag) flag_q <= 1'b0;
        end
    end

    assign rst_hit = evt.rst_hit;
    assign flag    = flag_q;
    assign rst_req = req_q;

    // R3: reset request lasts a single cycle
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        req_q |=> !req_q);

    // R6: flag holds until cleared
    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_flag) |=> flag_q);

    // R6: clear without a new event drops the flag
    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_flag && !evt.irq_hit) |=> !flag_q);

    // R5: the flag only rises with the interrupt enable set
    assert_irq_gate_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(irq_en));
endmodule

// File: rtl/dual_wdt.sv
module dual_wdt #(
    parameter int PRE_W = 15,
    parameter int CNT_W = 15
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [1:0]     addr,
    input  logic [CNT_W:0] wdata,
    output logic [CNT_W:0] rdata,
    output logic           irq,
    output logic           rst_req
);
    logic [CNT_W-1:0] cnt, rst_ref, irq_ref;
    logic             rst_en, irq_en, restart, clr_flag;
    logic             tick, rst_hit, flag;

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cnt(cnt), .flag(flag), .rdata(rdata),
        .rst_ref(rst_ref), .rst_en(rst_en), .irq_ref(irq_ref), .irq_en(irq_en),
        .restart(restart), .clr_flag(clr_flag)
    );

    wdt_timebase #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_time (
        .clk(clk), .rst(rst), .run(rst_en), .restart(restart),
        .wrap_now(rst_hit), .cnt(cnt), .tick(tick)
    );

    wdt_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst(rst), .tick(tick), .cnt(cnt),
        .rst_ref(rst_ref), .irq_ref(irq_ref), .irq_en(irq_en),
        .clr_flag(clr_flag), .rst_hit(rst_hit), .flag(flag), .rst_req(rst_req)
    );

    assign irq = flag;

    // R7: a service write restarts the count
    assert_service_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd2) |=> (cnt == '0));

    // R3: the counter is back at zero when the reset request is seen
    assert_cnt_cleared_R3: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (cnt == '0));
endmodule

// File: tb/test_dual_wdt.sv
module test_dual_wdt;
    localparam int CLK_PERIOD = 10;
    localparam int PRE_W = 3;
    localparam int CNT_W = 4;
    localparam int DW    = CNT_W + 1;
    localparam int STEP  = 1 << PRE_W;
    localparam int TOPV  = (1 << CNT_W) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq, rst_req;

    int total = 0;
    int bad   = 0;

    dual_wdt #(.PRE_W(PRE_W), .CNT_W(CNT_W)) i_dual_wdt (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .rst_req(rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = DW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic wait_rst(input int limit, output int k, output bit saw_irq);
        k = 0; saw_irq = 0;
        while (!rst_req && k < limit) begin
            @(negedge clk);
            k++;
            if (irq) saw_irq = 1;
        end
    endtask

    task automatic wait_irq(input int limit, output int k);
        k = 0;
        while (!irq && k < limit) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v, k;
        bit s;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, v); chk(v == 2*TOPV, "R1 rst ref", v, 2*TOPV);
        rd(2'd1, v); chk(v == 2*TOPV, "R1 irq ref", v, 2*TOPV);
        rd(2'd2, v); chk(v == 0, "R1 counter", v, 0);
        chk(!irq && !rst_req, "R1 outputs", int'(irq) + int'(rst_req), 0);

        // R2 disabled watchdog holds
        wait_rst(40, k, s);
        chk(k == 40, "R2 no reset while disabled", k, 40);
        rd(2'd2, v); chk(v == 0, "R2 counter held", v, 0);

        // R3 sweep every reset threshold
        for (int r = 0; r <= TOPV; r++) begin
            wr(2'd0, (r << 1) | 1);
            wait_rst(STEP*(r+1) + 4, k, s);
            chk(k == STEP*(r+1), "R3 reset timing", k, STEP*(r+1));
            @(negedge clk);
            chk(!rst_req, "R3 single pulse", int'(rst_req), 0);
            rd(2'd2, v); chk(v == 0, "R3 counter wrapped", v, 0);
            wr(2'd0, 0);
        end

        // R4 and R6 sweep every interrupt threshold below the top reset value
        for (int i = 0; i < TOPV; i++) begin
            wr(2'd1, (i << 1) | 1);
            wr(2'd0, (TOPV << 1) | 1);
            wait_irq(STEP*(TOPV+1), k);
            chk(k == STEP*(i+1), "R4 irq timing", k, STEP*(i+1));
            rd(2'd3, v); chk(v == 1, "R9 status read", v, 1);
            wr(2'd3, 0);
            chk(irq, "R6 write 0 keeps flag", int'(irq), 1);
            wr(2'd3, 1);
            chk(!irq, "R6 write 1 clears flag", int'(irq), 0);
            wr(2'd0, 0);
        end

        // R5 interrupt disabled, equal and inverted thresholds
        wr(2'd1, (2 << 1) | 0);
        wr(2'd0, (5 << 1) | 1);
        wait_rst(100, k, s);
        chk(k == 6*STEP && !s, "R5 irq enable clear", int'(s), 0);
        wr(2'd0, 0);
        wr(2'd1, (5 << 1) | 1);
        wr(2'd0, (5 << 1) | 1);
        wait_rst(100, k, s);
        chk(k == 6*STEP && !s, "R5 equal thresholds", int'(s), 0);
        wr(2'd0, 0);
        wr(2'd1, (7 << 1) | 1);
        wr(2'd0, (5 << 1) | 1);
        wait_rst(100, k, s);
        chk(k == 6*STEP && !s, "R5 irq above reset", int'(s), 0);
        wr(2'd0, 0);

        // R7 periodic service prevents reset, R9 live counter
        wr(2'd1, 0);
        wr(2'd0, (3 << 1) | 1);
        for (int n = 0; n < 10; n++) begin
            wait_rst(20, k, s);
            chk(k == 20, "R7 no reset while serviced", k, 20);
            rd(2'd2, v); chk(v == 20/STEP, "R9 live counter", v, 20/STEP);
            wr(2'd2, 0);
            rd(2'd2, v); chk(v == 0, "R7 service restart", v, 0);
        end
        wait_rst(60, k, s);
        chk(k == 4*STEP, "R7 reset after service stops", k, 4*STEP);

        // R8 reference writes restart
        repeat (20) @(negedge clk);
        wr(2'd1, 0);
        wait_rst(60, k, s);
        chk(k == 4*STEP, "R8 irq ref write restarts", k, 4*STEP);
        repeat (20) @(negedge clk);
        wr(2'd0, (3 << 1) | 1);
        wait_rst(60, k, s);
        chk(k == 4*STEP, "R8 rst ref write restarts", k, 4*STEP);

        // R9 readback of references
        wr(2'd1, (9 << 1) | 1);
        rd(2'd1, v); chk(v == 19, "R9 irq ref read", v, 19);
        rd(2'd0, v); chk(v == 7, "R9 rst ref read", v, 7);
        rd(2'd3, v); chk(v == 0, "R9 status clear read", v, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule